// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It drives four analog switches around an external integrator: a zeroing switch, the input switch and two reference switches of opposite sign. It also reads one comparator bit that is high while the integrator output is above zero. A start pulse runs one conversion in three steps. First the integrator is held at zero for a short settling time. Next the unknown input is integrated for a fixed number of clocks, a whole number of mains periods so that line hum averages out. Last, a reference of the opposite sign discharges the integrator, and the clocks are counted until the comparator changes state.

The count is the conversion result. A full-scale input, equal in size to the reference, discharges in as many clocks as the run-up took, so the run-down counter has the run-up length as its capacity. If the comparator has still not changed state when that capacity is reached, the conversion ends with an overrange flag. The sign of the input comes from the comparator value captured at the end of run-up and is reported with the result.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, overrange, result_neg are 0, result is 0, and only sw_zero is closed.
- R2: A start pulse while idle makes busy high from the next cycle. The zeroing switch then stays closed for exactly ZERO_CYCLES busy cycles.
- R3: The input switch is closed for exactly MAINS_CLKS*MAINS_PERIODS consecutive cycles per conversion (the run-up length, RUNUP).
- R4: In the cycle after the last run-up cycle, the input switch is open and one reference switch is closed. sw_ref_neg closes if cmp_pos was 1 at the final run-up clock edge, otherwise sw_ref_pos. The chosen switch stays closed for the whole run-down.
- R5: result equals the number of run-down cycles that pass before the first clock edge at which cmp_pos differs from its value captured at the end of run-up. The run-down lasts result+1 cycles.
- R6: When the comparator change and the counter reaching RUNUP fall on the same edge, the conversion is valid: result = RUNUP, overrange = 0.
- R7: If the count reaches RUNUP without a comparator change, done rises with overrange = 1 and result = RUNUP, after RUNUP+1 run-down cycles.
- R8: done is high for exactly one cycle, with busy low and sw_zero closed. result, result_neg and overrange hold their values until the next done.
- R9: start while busy is ignored; the conversion in progress keeps its timing and result.
- R10: result_neg is 1 exactly when cmp_pos was 0 at the final run-up edge (input not positive).
- R11: Exactly one of the four switch outputs is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only while idle) |
| cmp_pos | input | 1 | Comparator: 1 while the integrator output is above zero |
| sw_zero | output | 1 | Close the integrator zeroing switch |
| sw_input | output | 1 | Close the unknown-input switch |
| sw_ref_pos | output | 1 | Close the positive reference switch |
| sw_ref_neg | output | 1 | Close the negative reference switch |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe: result fields are new |
| result | output | CNT_W | Run-down clock count |
| result_neg | output | 1 | Input was not positive |
| overrange | output | 1 | Run-down hit its capacity without a zero crossing |

## Verification
Two events can fall on the same clock edge: the comparator change that ends a valid run-down, and the counter reaching its capacity that ends it as overrange. A positive input exactly equal to the reference makes both happen at once; the result must then be RUNUP with no overrange flag. An input just past full scale on either side must instead raise the flag after one more run-down cycle. An integrator model in the bench sweeps every integer input from beyond negative to beyond positive full scale. For each input, the bench works out the expected count, sign, flag and phase lengths arithmetically.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ZERO,
        PH_RUNUP,
        PH_RUNDOWN
    } phase_t;

    typedef struct packed {
        logic zero;
        logic inp;
        logic ref_pos;
        logic ref_neg;
    } switch_t;

    function automatic int cnt_width(int zero_len, int runup_len);
        int biggest;
        biggest = (zero_len > runup_len) ? zero_len : runup_len;
        return (biggest < 1) ? 1 : $clog2(biggest + 1);
    endfunction

    // Run-down discharges against the sign captured at the end of run-up.
    function automatic switch_t switches_for(phase_t ph, logic above_zero);
        switch_t s;
        s = '0;
        unique case (ph)
            PH_RUNUP:   s.inp = 1'b1;
            PH_RUNDOWN: begin
                s.ref_neg = above_zero;
                s.ref_pos = ~above_zero;
            end
            default:    s.zero = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dsc_timer.sv
module dsc_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dsc_switch_drive.sv
module dsc_switch_drive
    import dsc_pkg::*;
(
    input  phase_t  phase,
    input  logic    above_zero,
    output switch_t sw
);
    always_comb begin
        sw = switches_for(phase, above_zero);
    end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
    import dsc_pkg::*;
#(
    parameter int ZERO_CYCLES  = 4,
    parameter int RUNUP_CYCLES = 32,
    parameter int W            = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cmp_pos,
    input  logic [W-1:0] count,
    output phase_t       phase,
    output logic         above_zero,
    output logic         cnt_clear,
    output logic         cnt_en,
    output logic         done,
    output logic [W-1:0] result,
    output logic         result_neg,
    output logic         overrange
);
    localparam logic [W-1:0] ZERO_LAST  = W'(ZERO_CYCLES - 1);
    localparam logic [W-1:0] RUNUP_LAST = W'(RUNUP_CYCLES - 1);
    localparam logic [W-1:0] RD_LIMIT   = W'(RUNUP_CYCLES);

    logic zero_end, runup_end, at_limit, crossed, finish;

    always_comb begin
        zero_end  = (phase == PH_ZERO)    && (count == ZERO_LAST);
        runup_end = (phase == PH_RUNUP)   && (count == RUNUP_LAST);
        crossed   = (cmp_pos != above_zero);
        at_limit  = (count == RD_LIMIT);
        finish    = (phase == PH_RUNDOWN) && (crossed || at_limit);
        cnt_clear = ((phase == PH_IDLE) && start) || zero_end || runup_end || finish;
        cnt_en    = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            above_zero <= 1'b0;
            done       <= 1'b0;
            result     <= '0;
            result_neg <= 1'b0;
            overrange  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE:    if (start) phase <= PH_ZERO;
                PH_ZERO:    if (zero_end) phase <= PH_RUNUP;
                PH_RUNUP: begin
                    if (runup_end) begin
                        phase      <= PH_RUNDOWN;
                        above_zero <= cmp_pos;
                    end
                end
                PH_RUNDOWN: begin
                    if (finish) begin
                        phase      <= PH_IDLE;
                        done       <= 1'b1;
                        result_neg <= ~above_zero;
                        // a crossing on the limit edge is still a valid reading
                        overrange  <= ~crossed;
                        result     <= crossed ? count : RD_LIMIT;
                    end
                end
                default:    phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import dsc_pkg::*;
#(
    parameter int MAINS_CLKS    = 16,
    parameter int MAINS_PERIODS = 2,
    parameter int ZERO_CYCLES   = 4,
    localparam int RUNUP        = MAINS_CLKS * MAINS_PERIODS,
    localparam int CNT_W        = cnt_width(ZERO_CYCLES, RUNUP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_pos,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref_pos,
    output logic             sw_ref_neg,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             result_neg,
    output logic             overrange
);
    phase_t           phase;
    logic             above_zero, cnt_clear, cnt_en;
    logic [CNT_W-1:0] count;
    switch_t          sw;

    dsc_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .en    (cnt_en),
        .count (count)
    );

    dsc_fsm #(
        .ZERO_CYCLES  (ZERO_CYCLES),
        .RUNUP_CYCLES (RUNUP),
        .W            (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmp_pos    (cmp_pos),
        .count      (count),
        .phase      (phase),
        .above_zero (above_zero),
        .cnt_clear  (cnt_clear),
        .cnt_en     (cnt_en),
        .done       (done),
        .result     (result),
        .result_neg (result_neg),
        .overrange  (overrange)
    );

    dsc_switch_drive u_sw (
        .phase      (phase),
        .above_zero (above_zero),
        .sw         (sw)
    );

    assign sw_zero    = sw.zero;
    assign sw_input   = sw.inp;
    assign sw_ref_pos = sw.ref_pos;
    assign sw_ref_neg = sw.ref_neg;
    assign busy       = (phase != PH_IDLE);
endmodule

// File: rtl/dual_slope_ctrl_chk.sv
module dual_slope_ctrl_chk #(
    parameter int RUNUP = 32,
    parameter int W     = 6
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         sw_zero,
    input logic         sw_input,
    input logic         sw_ref_pos,
    input logic         sw_ref_neg,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         overrange
);
    logic [W:0] ru_len, rd_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            ru_len <= '0;
            rd_len <= '0;
        end else begin
            ru_len <= sw_input ? ru_len + 1'b1 : '0;
            rd_len <= (sw_ref_pos || sw_ref_neg) ? rd_len + 1'b1 : '0;
        end
    end

    // R11
    one_switch_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sw_zero, sw_input, sw_ref_pos, sw_ref_neg}) == 1);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && sw_zero));

    // R3
    runup_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_input) |-> (ru_len == (W+1)'(RUNUP)));

    // R4
    handover_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_input) |-> (sw_ref_pos || sw_ref_neg));

    // R4
    ref_pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sw_ref_pos |=> !sw_ref_neg);

    // R4
    ref_neg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sw_ref_neg |=> !sw_ref_pos);

    // R7
    rundown_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_ref_pos || sw_ref_neg) |-> (rd_len <= (W+1)'(RUNUP)));

    // R7
    ovr_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && overrange) |-> (result == W'(RUNUP)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && sw_zero));
endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(
    .RUNUP (RUNUP),
    .W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sw_zero    (sw_zero),
    .sw_input   (sw_input),
    .sw_ref_pos (sw_ref_pos),
    .sw_ref_neg (sw_ref_neg),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .overrange  (overrange)
);

// File: tb/tb_dual_slope_ctrl.sv
module tb_dual_slope_ctrl;
    localparam int MC   = 8;
    localparam int MP   = 4;
    localparam int ZC   = 3;
    localparam int RU   = MC * MP;
    localparam int CW   = $clog2(RU + 1);
    localparam int VREF = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cmp_pos;
    logic sw_zero, sw_input, sw_ref_pos, sw_ref_neg;
    logic busy, done, result_neg, overrange;
    logic [CW-1:0] result;

    int acc = 0;
    int vin = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dual_slope_ctrl #(
        .MAINS_CLKS    (MC),
        .MAINS_PERIODS (MP),
        .ZERO_CYCLES   (ZC)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmp_pos    (cmp_pos),
        .sw_zero    (sw_zero),
        .sw_input   (sw_input),
        .sw_ref_pos (sw_ref_pos),
        .sw_ref_neg (sw_ref_neg),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .result_neg (result_neg),
        .overrange  (overrange)
    );

    // integrator model: one step per clock through whichever switch is closed
    always @(posedge clk) begin
        if (rst || sw_zero) acc <= 0;
        else if (sw_input)  acc <= acc + vin;
        else if (sw_ref_pos) acc <= acc + VREF;
        else if (sw_ref_neg) acc <= acc - VREF;
    end
    assign cmp_pos = (acc > 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic convert(input int v, input bit poke);
        int exp_cnt, exp_res, exp_rd, n_busy, n_zero, n_in, n_rp, n_rn, n_multi, guard;
        bit exp_ovr, exp_neg, prev_in, hand_ok;
        logic [CW-1:0] held;
        if (v > 0) exp_cnt = (RU * v + VREF - 1) / VREF;
        else       exp_cnt = (RU * (-v)) / VREF + 1;
        exp_ovr = (exp_cnt > RU);
        exp_res = exp_ovr ? RU : exp_cnt;
        exp_rd  = exp_ovr ? RU + 1 : exp_cnt + 1;
        exp_neg = (v <= 0);
        vin = v;
        n_busy = 0; n_zero = 0; n_in = 0; n_rp = 0; n_rn = 0; n_multi = 0;
        prev_in = 1'b0; hand_ok = 1'b1; guard = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        while (!done && guard < 1000) begin
            guard++;
            if (busy) n_busy++;
            if (sw_zero) n_zero++;
            if (sw_input) n_in++;
            if (sw_ref_pos) n_rp++;
            if (sw_ref_neg) n_rn++;
            if ((sw_zero + sw_input + sw_ref_pos + sw_ref_neg) != 1) n_multi++;
            if (prev_in && !sw_input)
                hand_ok = exp_neg ? sw_ref_pos : sw_ref_neg;
            prev_in = sw_input;
            start = (poke && (n_busy == 5 || n_busy == ZC + RU + 1));
            @(negedge clk);
        end
        start = 1'b0;
        chk(n_zero == ZC, "R2 zeroing cycles", n_zero, ZC);
        chk(n_in == RU, "R3 run-up cycles", n_in, RU);
        chk(hand_ok, "R4 handover to reference", int'(hand_ok), 1);
        chk((exp_neg ? n_rn : n_rp) == 0, "R4 wrong reference cycles", exp_neg ? n_rn : n_rp, 0);
        chk(n_rp + n_rn == exp_rd, poke ? "R9 run-down cycles with start poked" : "R5 run-down cycles",
            n_rp + n_rn, exp_rd);
        chk(n_busy == ZC + RU + exp_rd, "R9 busy length", n_busy, ZC + RU + exp_rd);
        chk(n_multi == 0, "R11 single switch", n_multi, 0);
        chk(int'(result) == exp_res, exp_ovr ? "R7 overrange result" : (exp_res == RU ? "R6 full-scale tie" : "R5 result"),
            int'(result), exp_res);
        chk(overrange == exp_ovr, exp_res == RU ? "R6 R7 overrange flag" : "R7 overrange flag", int'(overrange), int'(exp_ovr));
        chk(result_neg == exp_neg, "R10 sign", int'(result_neg), int'(exp_neg));
        chk(!busy && sw_zero, "R8 idle with done", int'(busy), 0);
        held = result;
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(result == held, "R8 result held", int'(result), int'(held));
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0 && overrange == 1'b0 && result_neg == 1'b0, "R1 flags", int'({done, overrange, result_neg}), 0);
        chk(result == '0, "R1 result", int'(result), 0);
        chk(sw_zero && !sw_input && !sw_ref_pos && !sw_ref_neg, "R1 switches",
            int'({sw_zero, sw_input, sw_ref_pos, sw_ref_neg}), 8);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && sw_zero, "R1 idle after reset", int'(busy), 0);
        for (int v = -9; v <= 9; v++) begin
            convert(v, (v % 2) != 0);
        end
        // the tie and both sides of it once more, back to back
        convert(VREF, 1'b1);
        convert(VREF + 1, 1'b0);
        convert(-VREF, 1'b0);
        summary();
    end
endmodule